// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write a 64K x 8 asynchronous static RAM. A requester presents an address, a direction flag and write data on a valid/ready request channel. The controller then runs one complete memory cycle on the memory pins. Every phase of that cycle is counted in clock cycles set by parameters, so the memory's access time, write pulse width, data setup and bus release limits can be met at any clock rate. Read data comes back on a response channel that has a valid strobe and no ready.

Request channel rules: a request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. It drops on the edge that accepts a request and rises again once the memory cycle has fully ended, so a requester that holds `req_valid` high simply waits. The address, direction and write data are stored at acceptance, and the request pins may change freely after that. The response channel cannot apply back-pressure: `rsp_valid` is high for one cycle and the consumer must take `rsp_rdata` in that cycle.

On the memory side, the chip is selected only when the active-low select is low and the active-high select is high. The controller always moves both selects together. The data bus is split into an output, an output enable and an input, and the controller never drives the bus while the memory's outputs are enabled.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, the controller is idle. In that state `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the following cycle and stays low until the memory cycle is over.
- R3: `mem_we_n` or `mem_oe_n` falls only after the memory has been selected (`mem_cs_n`=0, `mem_cs`=1) with the same `mem_addr` for at least one cycle. `mem_addr` does not change while the memory is selected.
- R4: A read holds `mem_oe_n` low for exactly RD_CYC cycles and samples `mem_dq_i` on the edge that ends the last of them.
- R5: `rsp_valid` rises on the same edge on which `mem_oe_n` rises after a read, and stays high for exactly one cycle. `rsp_rdata` then holds the byte stored at the read address.
- R6: A write drives `mem_dq_oe` high with stable `mem_dq_o` for exactly SETUP_CYC cycles before `mem_we_n` falls. It holds `mem_we_n` low for exactly WR_CYC cycles with the data driven throughout, and keeps the data driven for one more cycle after `mem_we_n` rises.
- R7: `mem_dq_oe` is never high in a cycle where `mem_oe_n` is low.
- R8: After `mem_oe_n` rises, at least TURN_CYC cycles pass before `mem_dq_oe` rises.
- R9: Changes on `req_addr`, `req_write` and `req_wdata` after acceptance have no effect on the memory cycle in progress. The stored byte is the one presented at acceptance.
- R10: In the last cycle of a selection, and in the cycle before the address changes, both `mem_we_n` and `mem_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Byte address |
| req_wdata | input | DW (8) | Write byte |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | DW (8) | Read byte |
| mem_addr | output | AW (16) | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DW (8) | Data bus, value driven |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | DW (8) | Data bus, value received |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge, and that the memory returns stable data on `mem_dq_i` before the edge that ends the output-enable phase. The bench's memory model updates its output on the falling clock edge. That places the data well ahead of the sampling edge, and the model drives nothing while the output enable is high. The requester changes its pins only on falling edges. It scrambles them right after acceptance, which exercises the rule that they are ignored. Back-to-back read-then-write requests exercise the turnaround path.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RADDR  = 3'd1,
    ST_RACC   = 3'd2,
    ST_REND   = 3'd3,
    ST_WADDR  = 3'd4,
    ST_WDATA  = 3'd5,
    ST_WPULSE = 3'd6,
    ST_WHOLD  = 3'd7
  } asram_state_e;

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CW'(1));

  // a phase of zero cycles would never end
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/asram_turn_guard.sv
module asram_turn_guard #(
  parameter int CW   = 3,
  parameter int TURN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clear
);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (start) begin
      left <= CW'(TURN);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign clear = (left == '0);

  p_guard_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && left != '0) |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2,
  parameter int SETUP_CYC = 1,
  parameter int TURN_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int MAX_A = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_B = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  generate
    if (RD_CYC < 1 || WR_CYC < 1 || SETUP_CYC < 1 || TURN_CYC < 1) begin : g_bad_cfg
      $error("asram_ctrl: every phase count must be at least 1");
    end
  endgenerate

  asram_state_e  state, nxt;
  logic          ph_load, ph_last, turn_start, turn_clear;
  logic [CW-1:0] ph_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;
  logic          cs_n_q, cs_q, we_n_q, oe_n_q, dq_oe_q;

  // ---------------- sequencing ----------------
  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (req_valid) nxt = req_write ? ST_WADDR : ST_RADDR;
      ST_RADDR:  nxt = ST_RACC;
      ST_RACC:   if (ph_last) nxt = ST_REND;
      ST_REND:   nxt = ST_IDLE;
      ST_WADDR:  if (turn_clear) nxt = ST_WDATA;
      ST_WDATA:  if (ph_last) nxt = ST_WPULSE;
      ST_WPULSE: if (ph_last) nxt = ST_WHOLD;
      ST_WHOLD:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_RACC:   ph_val = CW'(RD_CYC);
      ST_WDATA:  ph_val = CW'(SETUP_CYC);
      ST_WPULSE: ph_val = CW'(WR_CYC);
      default:   ph_val = CW'(1);
    endcase
  end

  assign ph_load    = (nxt != state);
  assign turn_start = (state == ST_RACC) && ph_last;
  assign req_ready  = (state == ST_IDLE);

  asram_phase_cnt #(.CW(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last)
  );

  asram_turn_guard #(.CW(CW), .TURN(TURN_CYC)) u_turn (
    .clk   (clk),
    .rst_n (rst_n),
    .start (turn_start),
    .clear (turn_clear)
  );

  // ---------------- registered pin drive ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cs_n_q  <= 1'b1;
      cs_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state   <= nxt;
      cs_n_q  <= (nxt == ST_IDLE);
      cs_q    <= (nxt != ST_IDLE);
      we_n_q  <= (nxt != ST_WPULSE);
      oe_n_q  <= (nxt != ST_RACC);
      dq_oe_q <= (nxt == ST_WDATA) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (state == ST_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_q <= turn_start;
      if (turn_start) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_cs    = cs_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = dq_oe_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // ---------------- assertions ----------------
  logic [CW-1:0] oe_quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   oe_quiet <= CW'(TURN_CYC);
    else if (!mem_oe_n)           oe_quiet <= '0;
    else if (oe_quiet != CW'(TURN_CYC)) oe_quiet <= oe_quiet + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n && mem_cs));

  p_oe_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_cs_n && mem_cs));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_rsp_on_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid);

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_we_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_quiet >= CW'(TURN_CYC)));

  p_strobe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_cs_n) && (mem_cs_n || !$stable(mem_addr))) |-> $past(mem_we_n && mem_oe_n));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RD = 3;
  localparam int WR = 2;
  localparam int SU = 2;
  localparam int TURN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [7:0] dev [int];
  logic [7:0] refm [int];
  logic [7:0] last_rsp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(
    .AW(16), .DW(8), .RD_CYC(RD), .WR_CYC(WR), .SETUP_CYC(SU), .TURN_CYC(TURN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] rd_dev(input logic [15:0] a);
    return dev.exists(int'(a)) ? dev[int'(a)] : 8'h00;
  endfunction

  // ---------------- memory model and pin monitor (falling edge) ----------------
  logic        p_oe_n = 1'b1, p_we_n = 1'b1, p_sel = 1'b0, p_dq_oe = 1'b0, p_rsp = 1'b0;
  logic [15:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int oe_len = 0, we_len = 0, su_len = 0, gap = 100;

  always @(negedge clk) begin
    if (mon_on) begin
      automatic logic sel = !mem_cs_n && mem_cs;

      check(!(mem_dq_oe && !mem_oe_n), "R7 bus driven during read", int'(mem_dq_oe), 0);
      if (req_ready)
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins",
              int'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}), 'b10110);
      if (rsp_valid && p_rsp) check(1'b0, "R5 strobe longer than one cycle", 1, 0);
      if (rsp_valid) last_rsp = rsp_rdata;

      if (!mem_oe_n) begin
        if (p_oe_n) check(p_sel && p_addr == mem_addr, "R3 select before output enable",
                          int'(p_sel), 1);
        oe_len++;
        gap = 0;
      end else begin
        if (!p_oe_n) begin
          check(oe_len == RD, "R4 output enable length", oe_len, RD);
          check(rsp_valid, "R5 strobe with output enable release", int'(rsp_valid), 1);
          check(rsp_rdata == rd_ref(mem_addr), "R5 read data", int'(rsp_rdata),
                int'(rd_ref(mem_addr)));
          oe_len = 0;
        end
        if (gap < 100) gap++;
      end

      if (mem_dq_oe && !p_dq_oe)
        check(gap >= TURN, "R8 turnaround gap", gap, TURN);

      if (!mem_we_n) begin
        if (p_we_n) begin
          check(p_sel && p_addr == mem_addr, "R3 select before write enable", int'(p_sel), 1);
          check(su_len == SU, "R6 data setup cycles", su_len, SU);
        end
        check(mem_dq_oe, "R6 data driven in pulse", int'(mem_dq_oe), 1);
        dev[int'(mem_addr)] = mem_dq_o;
        we_len++;
      end else begin
        if (!p_we_n) begin
          check(we_len == WR, "R6 write pulse length", we_len, WR);
          check(mem_dq_oe && mem_dq_o == p_dq, "R6 data hold after pulse",
                int'(mem_dq_o), int'(p_dq));
          we_len = 0;
        end
        if (mem_dq_oe) su_len++;
        else su_len = 0;
      end

      if (p_sel && (!sel || mem_addr != p_addr))
        check(p_we_n && p_oe_n, "R10 strobes released before deselect",
              int'({p_we_n, p_oe_n}), 3);

      // memory output, ready well before the sampling edge
      mem_dq_i = (sel && mem_we_n && !mem_oe_n) ? rd_dev(mem_addr) : 8'h00;

      p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_sel = sel; p_dq_oe = mem_dq_oe;
      p_addr = mem_addr; p_dq = mem_dq_o; p_rsp = rsp_valid;
    end
  end

  // ---------------- requester ----------------
  task automatic xact(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(!req_ready, "R2 ready drops after accept", int'(req_ready), 0);
    // scramble the request pins: must be ignored (R9)
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    if (wr) refm[int'(a)] = d;
    while (!req_ready) @(negedge clk);
  endtask

  logic [15:0] pool [8];

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) pool[i] = 16'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check(mem_cs_n && !mem_cs, "R1 deselected after reset", int'({mem_cs_n, mem_cs}), 2);

    // directed corners
    xact(1'b1, 16'h0000, 8'hA5);
    xact(1'b1, 16'hFFFF, 8'h5A);
    xact(1'b0, 16'h0000, 8'h00);
    xact(1'b0, 16'hFFFF, 8'h00);
    xact(1'b1, 16'h1234, 8'h3C);
    xact(1'b0, 16'h1234, 8'h00);
    check(last_rsp == 8'h3C, "R9 byte held from acceptance", int'(last_rsp), 'h3C);
    xact(1'b0, 16'h0000, 8'h00);   // read immediately followed by a write: R8
    xact(1'b1, 16'h0000, 8'hC3);
    xact(1'b0, 16'h0000, 8'h00);
    check(last_rsp == 8'hC3, "R9 rewrite after turnaround", int'(last_rsp), 'hC3);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      automatic int pick = int'($urandom % 6);
      automatic logic [15:0] a = (pick == 0) ? 16'h0000 :
                                 (pick == 1) ? 16'hFFFF : pool[$urandom % 8];
      xact(1'($urandom % 2), a, 8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule